// File: doc/BRIEF.md
# Two-Stage Segmented Ternary Match Array

This block is a small ternary match array that cuts the comparison work of each search by splitting every stored word into two segments. A short leading segment, made of the low `PRE_W` bits, is compared for every valid entry in the first stage. Only the entries that pass that comparison take part in the second stage, where the remaining high bits are compared. An entry reports a final match only when both stages agree.

Each stored bit has a care flag, so a stored bit can be a don't-care. The search key comes with a global mask that can exclude key bits from the comparison. Both rules apply in the same way to the two segments. The width of the leading segment is a parameter. It is chosen from the statistics of the stored data, because a random mismatch anywhere in the leading segment stops the second stage for that entry.

A saturating activity counter adds up how many entries were enabled for the second stage. That number is a measure of the comparison energy actually spent.

Top module: `seg_tcam`

## Requirements
- R1: After reset, `match_valid` is 0, `match_vec` is 0 and `act_count` is 0. Every entry is invalid, so a search with any key matches no entry and adds nothing to the counter.
- R2: A cycle with `wr_en` high stores `wr_value` and `wr_care` into entry `wr_idx` and marks that entry valid. Searches strobed after that cycle see the new contents.
- R3: A bit position takes part in a comparison only when the stored care bit is 1 and the global mask bit `srch_mask` is 0. A mask bit of 1 ignores that key bit. Any other position always agrees. The same rule holds in both segments.
- R4: An entry passes stage one when it is valid and no compared bit differs in the leading segment, bits [PRE_W-1:0].
- R5: The final match bit `match_vec[e]` is 1 only when entry e passed stage one and no compared bit differs in bits [WIDTH-1:PRE_W]. An entry that failed stage one reports 0 whatever its high bits hold.
- R6: Suppose `srch_go` is sampled high at clock edge k. Then `match_valid` is still 0 after edge k. The result is in `match_vec`, with `match_valid` high for one cycle, after edge k+1. When no result is delivered, `match_vec` holds its last value.
- R7: Along with each result, `act_count` grows by the number of entries that passed stage one in that search. Entries that failed stage one add nothing.
- R8: `act_count` stops at 2^CNT_W-1 and stays there until reset.
- R9: Searches strobed on consecutive cycles each produce their own result, on consecutive cycles, in strobe order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_idx | input | IW | Entry index to write |
| wr_value | input | WIDTH | Stored bit values |
| wr_care | input | WIDTH | Stored care flags (0 = don't-care) |
| srch_go | input | 1 | Search strobe |
| srch_key | input | WIDTH | Search key |
| srch_mask | input | WIDTH | Global mask (1 = ignore key bit) |
| match_vec | output | ENTRIES | Final per-entry match result |
| match_valid | output | 1 | One-cycle pulse when match_vec is new |
| act_count | output | CNT_W | Saturating count of stage-two enables |

## Verification
Suppose stage-one gating goes wrong, for example every entry is let into stage two, or the key bits are split at the wrong place. The counter then departs from the model on the very next result, even when the match vector is still correct. A stage-one register that is wrong shows up two edges after its strobe, as a match bit or a counter step that differs from the model. A wrong pipeline or key latch shows as results that are swapped or shifted during back-to-back searches. A counter that wraps instead of saturating shows as a sudden drop in the value.

// File: rtl/seg_tcam.sv
module seg_tcam #(
  parameter int ENTRIES = 8,
  parameter int WIDTH   = 16,
  parameter int PRE_W   = 4,
  parameter int CNT_W   = 16,
  localparam int IW     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int MAIN_W = WIDTH - PRE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [IW-1:0]      wr_idx,
  input  logic [WIDTH-1:0]   wr_value,
  input  logic [WIDTH-1:0]   wr_care,
  input  logic               srch_go,
  input  logic [WIDTH-1:0]   srch_key,
  input  logic [WIDTH-1:0]   srch_mask,
  output logic [ENTRIES-1:0] match_vec,
  output logic               match_valid,
  output logic [CNT_W-1:0]   act_count
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [WIDTH-1:0]   tv [ENTRIES];
  logic [WIDTH-1:0]   tc [ENTRIES];
  logic [ENTRIES-1:0] tvld;

  logic [ENTRIES-1:0] pre_pass, main_pass, s1_hit;
  logic               s1_valid;
  logic [MAIN_W-1:0]  s1_key, s1_mask;
  logic [CNT_W:0]     cnt_sum;

  always_ff @(posedge clk) begin
    if (wr_en && (int'(wr_idx) < ENTRIES)) begin
      tv[wr_idx] <= wr_value;
      tc[wr_idx] <= wr_care;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tvld <= '0;
    else if (wr_en && (int'(wr_idx) < ENTRIES)) tvld[wr_idx] <= 1'b1;
  end

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    wire [PRE_W-1:0] pre_diff =
      (srch_key[PRE_W-1:0] ^ tv[e][PRE_W-1:0]) & tc[e][PRE_W-1:0] & ~srch_mask[PRE_W-1:0];
    wire [MAIN_W-1:0] main_diff =
      (s1_key ^ tv[e][WIDTH-1:PRE_W]) & tc[e][WIDTH-1:PRE_W] & ~s1_mask;
    assign pre_pass[e]  = tvld[e] & ~|pre_diff;
    assign main_pass[e] = s1_hit[e] & ~|main_diff;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_hit   <= '0;
      s1_key   <= '0;
      s1_mask  <= '0;
    end else begin
      s1_valid <= srch_go;
      if (srch_go) begin
        s1_hit  <= pre_pass;
        s1_key  <= srch_key[WIDTH-1:PRE_W];
        s1_mask <= srch_mask[WIDTH-1:PRE_W];
      end
    end
  end

  always_comb begin
    cnt_sum = {1'b0, act_count};
    for (int e = 0; e < ENTRIES; e++) cnt_sum = cnt_sum + (CNT_W+1)'(s1_hit[e]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_vec   <= '0;
      match_valid <= 1'b0;
      act_count   <= '0;
    end else begin
      match_valid <= s1_valid;
      if (s1_valid) begin
        match_vec <= main_pass;
        act_count <= cnt_sum[CNT_W] ? CNT_MAX : cnt_sum[CNT_W-1:0];
      end
    end
  end

  // R5
  final_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid |=> ((match_vec & ~$past(s1_hit)) == '0));

  // R6
  valid_follows_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match_valid |-> $past(s1_valid));

  // R6
  vec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !match_valid |-> $stable(match_vec));

  // R7
  count_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_count >= $past(act_count));

  // R8
  count_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(act_count) == CNT_MAX) |-> (act_count == CNT_MAX));

  // R4
  invalid_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    srch_go |=> ((s1_hit & ~$past(tvld)) == '0));

endmodule

// File: tb/seg_tcam_tb.sv
module seg_tcam_tb;
  localparam int ENTRIES = 8;
  localparam int WIDTH   = 16;
  localparam int PRE_W   = 4;
  localparam int CNT_W   = 10;
  localparam int IW      = 3;
  localparam int CMAX    = (1 << CNT_W) - 1;
  localparam logic [WIDTH-1:0] PRE_M = (WIDTH'(1) << PRE_W) - 1;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, srch_go = 0;
  logic [IW-1:0] wr_idx = '0;
  logic [WIDTH-1:0] wr_value = '0, wr_care = '0, srch_key = '0, srch_mask = '0;
  logic [ENTRIES-1:0] match_vec;
  logic match_valid;
  logic [CNT_W-1:0] act_count;

  seg_tcam #(.ENTRIES(ENTRIES), .WIDTH(WIDTH), .PRE_W(PRE_W), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_value(wr_value),
    .wr_care(wr_care), .srch_go(srch_go), .srch_key(srch_key), .srch_mask(srch_mask),
    .match_vec(match_vec), .match_valid(match_valid), .act_count(act_count));

  always #2 clk = ~clk;

  int checks = 0, fails = 0, exp_cnt = 0;
  bit done = 0;
  logic [WIDTH-1:0] m_val [ENTRIES];
  logic [WIDTH-1:0] m_care [ENTRIES];
  bit m_vld [ENTRIES];

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int n_pre(logic [WIDTH-1:0] k, logic [WIDTH-1:0] m);
    int n = 0;
    for (int e = 0; e < ENTRIES; e++)
      if (m_vld[e] && ((((k ^ m_val[e]) & m_care[e] & ~m) & PRE_M) == '0)) n++;
    return n;
  endfunction

  function automatic logic [ENTRIES-1:0] exp_vec(logic [WIDTH-1:0] k, logic [WIDTH-1:0] m);
    logic [ENTRIES-1:0] v = '0;
    for (int e = 0; e < ENTRIES; e++)
      v[e] = m_vld[e] && (((k ^ m_val[e]) & m_care[e] & ~m) == '0);
    return v;
  endfunction

  task automatic add_cnt(int n);
    exp_cnt = (exp_cnt + n > CMAX) ? CMAX : exp_cnt + n;
  endtask

  task automatic do_write(int idx, logic [WIDTH-1:0] v, logic [WIDTH-1:0] c);
    @(negedge clk);
    wr_en = 1; wr_idx = IW'(idx); wr_value = v; wr_care = c;
    @(negedge clk);
    wr_en = 0;
    m_val[idx] = v; m_care[idx] = c; m_vld[idx] = 1;
  endtask

  task automatic do_search(logic [WIDTH-1:0] k, logic [WIDTH-1:0] m, string req);
    logic [ENTRIES-1:0] ev;
    ev = exp_vec(k, m);
    @(negedge clk);
    srch_go = 1; srch_key = k; srch_mask = m;
    @(negedge clk);
    srch_go = 0;
    chk(match_valid == 0, "R6 valid early", 64'(match_valid), 0);
    @(negedge clk);
    add_cnt(n_pre(k, m));
    chk(match_valid == 1, "R6 valid pulse", 64'(match_valid), 1);
    chk(match_vec == ev, req, 64'(match_vec), 64'(ev));
    chk(int'(act_count) == exp_cnt, "R7 count", 64'(act_count), 64'(exp_cnt));
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int e = 0; e < ENTRIES; e++) begin m_val[e] = '0; m_care[e] = '0; m_vld[e] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(match_valid == 0 && match_vec == 0 && act_count == 0, "R1 reset",
        {match_vec, match_valid, 54'(act_count)}, 0);
    do_search(16'h0000, 16'hFFFF, "R1 empty no match");

    // R2 R4 R5 exact entry
    do_write(0, 16'h1234, 16'hFFFF);
    do_search(16'h1234, 16'h0000, "R2 exact match");
    // R5 entry1 high bits don't-care; entry0 passes stage one but fails main
    do_write(1, 16'h1234, 16'h000F);
    do_search(16'hFFF4, 16'h0000, "R5 main gate");
    chk(match_vec == 8'b0000_0010, "R5 stage1-only entry not matched", 64'(match_vec), 2);
    // R4 mismatch in leading segment: nothing counted
    do_write(2, 16'h5678, 16'hFFFF);
    do_search(16'h5670, 16'h0000, "R4 pre mismatch");
    // R3 global mask covers the differing leading bits
    do_search(16'h567F, 16'h000F, "R3 mask pre");
    // R3 stored don't-care in leading segment
    do_write(3, 16'hABC0, 16'hFFF0);
    do_search(16'hABC9, 16'h0000, "R3 care pre");
    // R3 mask in main segment
    do_search(16'h0678, 16'hF000, "R3 mask main");

    // R9 back-to-back searches
    begin
      logic [ENTRIES-1:0] ea, eb;
      int na, nb;
      ea = exp_vec(16'h1234, 16'h0); na = n_pre(16'h1234, 16'h0);
      eb = exp_vec(16'h5678, 16'h0); nb = n_pre(16'h5678, 16'h0);
      @(negedge clk);
      srch_go = 1; srch_key = 16'h1234; srch_mask = 0;
      @(negedge clk);
      srch_key = 16'h5678;
      @(negedge clk);
      srch_go = 0;
      add_cnt(na);
      chk(match_valid && match_vec == ea, "R9 first result", 64'(match_vec), 64'(ea));
      chk(int'(act_count) == exp_cnt, "R9 first count", 64'(act_count), 64'(exp_cnt));
      @(negedge clk);
      add_cnt(nb);
      chk(match_valid && match_vec == eb, "R9 second result", 64'(match_vec), 64'(eb));
      chk(int'(act_count) == exp_cnt, "R9 second count", 64'(act_count), 64'(exp_cnt));
      @(negedge clk);
      chk(match_valid == 0 && match_vec == eb, "R6 hold", 64'(match_vec), 64'(eb));
    end

    // random mix
    for (int e = 0; e < ENTRIES; e++)
      do_write(e, WIDTH'($urandom), WIDTH'($urandom | $urandom | $urandom));
    for (int i = 0; i < 120; i++) begin
      int pick = int'($urandom % ENTRIES);
      logic [WIDTH-1:0] k = m_val[pick] ^ WIDTH'($urandom & $urandom & $urandom);
      logic [WIDTH-1:0] m = WIDTH'($urandom & $urandom & $urandom & $urandom);
      if (i % 10 == 9) do_write(int'($urandom % ENTRIES), WIDTH'($urandom), WIDTH'($urandom | $urandom));
      do_search(k, m, "R5 random");
    end

    // R8 saturation: every entry passes stage one
    for (int i = 0; i < (CMAX / ENTRIES) + 4; i++) do_search(16'h0, 16'hFFFF, "R8 all pass");
    chk(int'(act_count) == CMAX, "R8 saturated", 64'(act_count), 64'(CMAX));

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule